// File: doc/BRIEF.md
# Register-File Sorting Engine

This block holds a small bank of equal-width registers and sorts them in place into ascending unsigned order. A host first fills the bank through a write port made up of a data bus, an address and a write strobe. It then raises `start`. A nine-state controller sorts the bank with a nested compare-and-swap loop. When the sort is finished the controller raises `done`. The host reads the results back through a separate read port.

The datapath has the register bank, two working registers A and B, one unsigned less-than comparator, and two index counters Ci and Cj. Ci is the outer loop index and Cj is the inner loop index. Multiplexers choose the following:
- the address, either Ci or Cj;
- the data on the internal write bus, either A or B;
- the write source, either the host or the internal bus.

For each outer index i, A is loaded from R[i]. Each later register R[j] is then loaded into B. When B < A, the controller performs a swap:
- B is written into R[i];
- A is written into R[j];
- A is reloaded from R[i].

The swap takes three cycles, because the write bus carries only one value per cycle.

The controller has nine states, with these transitions:
- ST_IDLE accepts host writes. It goes to ST_LOAD_A when `start` is high.
- ST_LOAD_A loads A from R[Ci] and loads Cj with Ci+1. It goes to ST_LOAD_B.
- ST_LOAD_B loads B from R[Cj]. It goes to ST_COMPARE.
- ST_COMPARE goes to ST_WRITE_I if B < A, and to ST_STEP otherwise.
- ST_WRITE_I writes B into R[Ci]. It goes to ST_WRITE_J.
- ST_WRITE_J writes A into R[Cj]. It goes to ST_RELOAD_A.
- ST_RELOAD_A reloads A from R[Ci]. It goes to ST_STEP.
- ST_STEP decides the next step:
  - if Cj is not the last index, it increments Cj and goes to ST_LOAD_B;
  - if Cj is the last index and Ci is not k−2, it increments Ci and goes to ST_LOAD_A;
  - if Cj is the last index and Ci is k−2, it goes to ST_DONE.
- ST_DONE drives `done` high. It stays in ST_DONE while `start` is high and returns to ST_IDLE when `start` is low.

Top module: `regsort_top`

## Requirements
- R1: A synchronous active-high `rst` puts the controller in ST_IDLE with `done` low and both index counters at 0. Register contents written before the reset are still read back unchanged after it.
- R2: In ST_IDLE with `start` low, a cycle with `wr_init` high writes `data_in` into the register selected by `wr_addr`, which is a binary index from 0 to k−1. A `wr_init` pulse while `start` is high leaves every register unchanged.
- R3: With `rd_en` high, `data_out` shows the current contents of the register at `rd_addr` in the same cycle. With `rd_en` low, `data_out` is zero.
- R4: After a sort, reading addresses 0 to k−1 gives a non-decreasing sequence under unsigned comparison. That sequence is a permutation of the loaded values.
- R5: A swap happens only when B < A holds strictly, under unsigned comparison. Equal values are not swapped.
- R6: `done` first reads high on the (k + 3·k(k−1)/2 + 3·S)th falling clock edge after `start` was raised, where S is the number of swaps the loop makes. For k = 4 this is 22 + 3·S.
- R7: `done` stays high for as long as `start` stays high. One cycle after `start` is seen low, the controller is back in ST_IDLE, `done` is low and loads are accepted again.
- R8: The outer index Ci never exceeds k−2. During an inner pass (ST_LOAD_B to ST_STEP), Cj is always greater than Ci.
- R9: A swap is always two writes on consecutive cycles, first to R[Ci] and then to R[Cj], followed by a reload of A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start the sort; hold high to keep `done` |
| wr_init | input | 1 | Host write strobe, used in idle only |
| wr_addr | input | IDX_W | Host write address |
| data_in | input | DATA_W | Host write data |
| rd_en | input | 1 | Read enable for `data_out` |
| rd_addr | input | IDX_W | Read address |
| data_out | output | DATA_W | Read data, zero when not enabled |
| done | output | 1 | Sort finished (state ST_DONE) |

## Verification
The assertions check the following on every cycle:
- while `done` is high, the bank is in order;
- the bank stays unchanged in idle when no host write is accepted;
- Ci and Cj stay inside their loop bounds;
- every swap runs the sequence write-Ri, write-Rj, reload-A;
- `done` is held while `start` is high and drops once `start` is low.

Only the bench scenarios can show that the sorted result is a permutation of the loaded data. They also show the strict-less-than rule, through the exact start-to-done latency on ties. They cover unsigned ordering at the sign-bit boundary, the effect of reset on the contents, and writes being ignored while `start` is high.

// File: rtl/regsort_pkg.sv
package regsort_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_LOAD_A,
        ST_LOAD_B,
        ST_COMPARE,
        ST_WRITE_I,
        ST_WRITE_J,
        ST_RELOAD_A,
        ST_STEP,
        ST_DONE
    } sort_state_e;

    typedef struct packed {
        logic int_wr;    // internal write into the bank
        logic addr_cj;   // 1: address Cj, 0: address Ci
        logic bus_a;     // 1: write bus carries A, 0: carries B
        logic ld_a;
        logic ld_b;
        logic clr_ci;
        logic inc_ci;
        logic init_cj;   // Cj <= Ci + 1
        logic inc_cj;
        logic idle;
        logic done;
    } ctrl_t;

endpackage

// File: rtl/regsort_bank.sv
module regsort_bank #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                           clk,
    input  logic                           we,
    input  logic [IDX_W-1:0]               waddr,
    input  logic [DATA_W-1:0]              wdata,
    input  logic [IDX_W-1:0]               raddr_a,
    output logic [DATA_W-1:0]              rdata_a,
    input  logic [IDX_W-1:0]               raddr_b,
    output logic [DATA_W-1:0]              rdata_b,
    output logic [DEPTH-1:0][DATA_W-1:0]   regs
);

    logic [DEPTH-1:0] row_we;

    // address decoder plus one register per row
    for (genvar r = 0; r < DEPTH; r++) begin : g_row
        assign row_we[r] = we && (waddr == IDX_W'(r));
        always_ff @(posedge clk) begin
            if (row_we[r]) regs[r] <= wdata;
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

endmodule

// File: rtl/regsort_counters.sv
module regsort_counters #(
    parameter int DEPTH  = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_ci,
    input  logic             inc_ci,
    input  logic             init_cj,
    input  logic             inc_cj,
    output logic [IDX_W-1:0] ci,
    output logic [IDX_W-1:0] cj,
    output logic             ci_last,
    output logic             cj_last
);

    localparam logic [IDX_W-1:0] CI_END = IDX_W'(DEPTH - 2);
    localparam logic [IDX_W-1:0] CJ_END = IDX_W'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst || clr_ci) ci <= '0;
        else if (inc_ci)   ci <= ci + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)          cj <= '0;
        else if (init_cj) cj <= ci + 1'b1;
        else if (inc_cj)  cj <= cj + 1'b1;
    end

    assign ci_last = (ci == CI_END);
    assign cj_last = (cj == CJ_END);

endmodule

// File: rtl/regsort_ctrl.sv
module regsort_ctrl
    import regsort_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        b_lt_a,
    input  logic        ci_last,
    input  logic        cj_last,
    output sort_state_e state,
    output ctrl_t       ctl
);

    sort_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_d;
    end

    // next state
    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:     if (start) state_d = ST_LOAD_A;
            ST_LOAD_A:   state_d = ST_LOAD_B;
            ST_LOAD_B:   state_d = ST_COMPARE;
            ST_COMPARE:  state_d = b_lt_a ? ST_WRITE_I : ST_STEP;
            ST_WRITE_I:  state_d = ST_WRITE_J;
            ST_WRITE_J:  state_d = ST_RELOAD_A;
            ST_RELOAD_A: state_d = ST_STEP;
            ST_STEP: begin
                if (!cj_last)     state_d = ST_LOAD_B;
                else if (ci_last) state_d = ST_DONE;
                else              state_d = ST_LOAD_A;
            end
            ST_DONE:     if (!start) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ctl = '0;
        unique case (state)
            ST_IDLE: begin
                ctl.idle   = 1'b1;
                ctl.clr_ci = 1'b1;
            end
            ST_LOAD_A: begin
                ctl.ld_a    = 1'b1;
                ctl.init_cj = 1'b1;
            end
            ST_LOAD_B: begin
                ctl.ld_b    = 1'b1;
                ctl.addr_cj = 1'b1;
            end
            ST_COMPARE: ;
            ST_WRITE_I: begin
                ctl.int_wr = 1'b1;
            end
            ST_WRITE_J: begin
                ctl.int_wr  = 1'b1;
                ctl.addr_cj = 1'b1;
                ctl.bus_a   = 1'b1;
            end
            ST_RELOAD_A: begin
                ctl.ld_a = 1'b1;
            end
            ST_STEP: begin
                ctl.inc_cj = !cj_last;
                ctl.inc_ci = cj_last && !ci_last;
            end
            ST_DONE: begin
                ctl.done = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/regsort_top.sv
module regsort_top
    import regsort_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              wr_init,
    input  logic [IDX_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              rd_en,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] data_out,
    output logic              done
);

    sort_state_e                  state_q;
    ctrl_t                        ctl;
    logic [IDX_W-1:0]             ci_q, cj_q, sel_addr, waddr;
    logic                         ci_last, cj_last, b_lt_a, host_we, we;
    logic [DATA_W-1:0]            a_q, b_q, wbus, wdata, rd_int, rd_ext;
    logic [DEPTH-1:0][DATA_W-1:0] bank_q;

    regsort_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .b_lt_a  (b_lt_a),
        .ci_last (ci_last),
        .cj_last (cj_last),
        .state   (state_q),
        .ctl     (ctl)
    );

    regsort_counters #(.DEPTH(DEPTH)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .clr_ci  (ctl.clr_ci),
        .inc_ci  (ctl.inc_ci),
        .init_cj (ctl.init_cj),
        .inc_cj  (ctl.inc_cj),
        .ci      (ci_q),
        .cj      (cj_q),
        .ci_last (ci_last),
        .cj_last (cj_last)
    );

    // address and write-source muxes
    assign sel_addr = ctl.addr_cj ? cj_q : ci_q;
    assign wbus     = ctl.bus_a ? a_q : b_q;
    assign host_we  = ctl.idle && wr_init && !start;
    assign we       = host_we || ctl.int_wr;
    assign waddr    = host_we ? wr_addr : sel_addr;
    assign wdata    = host_we ? data_in : wbus;

    regsort_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
        .clk     (clk),
        .we      (we),
        .waddr   (waddr),
        .wdata   (wdata),
        .raddr_a (sel_addr),
        .rdata_a (rd_int),
        .raddr_b (rd_addr),
        .rdata_b (rd_ext),
        .regs    (bank_q)
    );

    // working registers and comparator
    always_ff @(posedge clk) begin
        if (ctl.ld_a) a_q <= rd_int;
        if (ctl.ld_b) b_q <= rd_int;
    end

    assign b_lt_a   = (b_q < a_q);
    assign data_out = rd_en ? rd_ext : '0;
    assign done     = ctl.done;

endmodule

// File: rtl/regsort_checker.sv
module regsort_checker
    import regsort_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         start,
    input logic                         wr_init,
    input logic                         done,
    input sort_state_e                  state,
    input logic [IDX_W-1:0]             ci,
    input logic [IDX_W-1:0]             cj,
    input logic [DEPTH-1:0][DATA_W-1:0] bank
);

    logic in_order;
    logic inner;

    always_comb begin
        in_order = 1'b1;
        for (int r = 1; r < DEPTH; r++)
            if (bank[r] < bank[r-1]) in_order = 1'b0;
    end

    assign inner = (state == ST_LOAD_B) || (state == ST_COMPARE) ||
                   (state == ST_WRITE_I) || (state == ST_WRITE_J) ||
                   (state == ST_RELOAD_A) || (state == ST_STEP);

    p_sorted_at_done_r4: assert property (@(posedge clk) disable iff (rst)
        done |-> in_order);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !(wr_init && !start)) |=> $stable(bank));

    p_done_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> done);

    p_done_release_r7: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (!done && state == ST_IDLE));

    p_ci_bound_r8: assert property (@(posedge clk) disable iff (rst)
        ci <= IDX_W'(DEPTH - 2));

    p_cj_above_ci_r8: assert property (@(posedge clk) disable iff (rst)
        inner |-> (cj > ci));

    p_swap_seq_i_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRITE_I) |=> (state == ST_WRITE_J));

    p_swap_seq_j_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WRITE_J) |=> (state == ST_RELOAD_A));

endmodule

bind regsort_top regsort_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .wr_init (wr_init),
    .done    (done),
    .state   (state_q),
    .ci      (ci_q),
    .cj      (cj_q),
    .bank    (bank_q)
);

// File: tb/regsort_top_bench.sv
`timescale 1ns/1ps
module regsort_top_bench;

    localparam int DW = 8;
    localparam int K  = 4;
    localparam int AW = 2;

    logic          clk = 1'b0;
    logic          rst, start, wr_init, rd_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [DW-1:0] data_in, data_out;
    logic          done;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;   // 125 MHz

    regsort_top #(.DATA_W(DW), .DEPTH(K)) u_regsort_top (
        .clk(clk), .rst(rst), .start(start), .wr_init(wr_init),
        .wr_addr(wr_addr), .data_in(data_in), .rd_en(rd_en),
        .rd_addr(rd_addr), .data_out(data_out), .done(done)
    );

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference loop from the requirements: result and swap count
    task automatic model(input logic [K-1:0][DW-1:0] v,
                         output logic [K-1:0][DW-1:0] s, output int swaps);
        logic [DW-1:0] a, t;
        s = v; swaps = 0;
        for (int i = 0; i <= K - 2; i++) begin
            a = s[i];
            for (int j = i + 1; j <= K - 1; j++) begin
                if (s[j] < a) begin
                    t = s[j]; s[j] = a; s[i] = t; a = s[i]; swaps++;
                end
            end
        end
    endtask

    task automatic load_all(input logic [K-1:0][DW-1:0] v);
        for (int r = 0; r < K; r++) begin
            @(negedge clk);
            wr_init = 1'b1; wr_addr = AW'(r); data_in = v[r];
        end
        @(negedge clk);
        wr_init = 1'b0;
    endtask

    task automatic read_word(input int addr, output logic [DW-1:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = AW'(addr);
        #1 d = data_out;
        rd_en = 1'b0;
    endtask

    task automatic read_expect(input string req, input logic [K-1:0][DW-1:0] e);
        logic [DW-1:0] d;
        for (int r = 0; r < K; r++) begin
            read_word(r, d);
            check(req, $sformatf("R[%0d]", r), d, e[r]);
        end
    endtask

    // raise start, measure latency to done, check result, release start
    task automatic sort_and_check(input string name, input logic [K-1:0][DW-1:0] v);
        logic [K-1:0][DW-1:0] exp;
        logic [DW-1:0] d, prev;
        int swaps, cnt, mult;
        bit ok;
        model(v, exp, swaps);
        load_all(v);
        @(negedge clk);
        start = 1'b1;
        cnt = 0;
        while (!done && cnt < 200) begin
            @(negedge clk);
            cnt++;
        end
        check("R6", {name, " latency"}, cnt, K + 3*K*(K-1)/2 + 3*swaps);
        check("R5", {name, " swap-cost latency"}, cnt - (K + 3*K*(K-1)/2), 3*swaps);
        // R4: ascending and a permutation of the inputs
        ok = 1'b1; prev = '0;
        for (int r = 0; r < K; r++) begin
            read_word(r, d);
            if (r > 0 && d < prev) ok = 1'b0;
            prev = d;
            mult = 0;
            for (int q = 0; q < K; q++) if (v[q] == d) mult++;
            if (mult == 0) ok = 1'b0;
            if (d != exp[r]) ok = 1'b0;
        end
        check("R4", {name, " sorted permutation"}, ok, 1);
        repeat (3) @(negedge clk);
        check("R7", {name, " done held"}, done, 1);
        start = 1'b0;
        @(negedge clk);
        check("R7", {name, " done released"}, done, 0);
    endtask

    task automatic t_reset;
        logic [K-1:0][DW-1:0] v;
        v = {8'h44, 8'h33, 8'h22, 8'h11};
        load_all(v);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1", "done after reset", done, 0);
        read_expect("R1", v);
    endtask

    task automatic t_load_read;
        logic [K-1:0][DW-1:0] v;
        v = {8'hA5, 8'h5A, 8'h01, 8'hFE};
        load_all(v);
        read_expect("R2", v);
        @(negedge clk); rd_en = 1'b0; rd_addr = 2'd1;
        #1 check("R3", "data_out disabled", data_out, 0);
    endtask

    task automatic t_write_ignored;
        logic [K-1:0][DW-1:0] v, exp;
        int swaps;
        v = {8'h09, 8'h03, 8'h07, 8'h01};
        model(v, exp, swaps);
        load_all(v);
        @(negedge clk); start = 1'b1;
        while (!done) @(negedge clk);
        wr_init = 1'b1; wr_addr = 2'd0; data_in = 8'hEE;
        @(negedge clk); wr_init = 1'b0;
        start = 1'b0;
        @(negedge clk);
        read_expect("R2", exp);
        // loads accepted again after release
        @(negedge clk); wr_init = 1'b1; wr_addr = 2'd2; data_in = 8'h5C;
        @(negedge clk); wr_init = 1'b0;
        exp[2] = 8'h5C;
        read_expect("R7", exp);
    endtask

    initial begin
        #(8 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [K-1:0][DW-1:0] rv;
        rst = 1'b1; start = 1'b0; wr_init = 1'b0; rd_en = 1'b0;
        wr_addr = '0; rd_addr = '0; data_in = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check("R1", "done out of reset", done, 0);
        t_load_read();
        t_reset();
        sort_and_check("reverse", {8'd1, 8'd2, 8'd3, 8'd4});
        sort_and_check("ascending", {8'd40, 8'd30, 8'd20, 8'd10});
        sort_and_check("all equal", {8'd5, 8'd5, 8'd5, 8'd5});
        sort_and_check("ties", {8'd2, 8'd7, 8'd2, 8'd7});
        sort_and_check("unsigned msb", {8'h00, 8'hFF, 8'h7F, 8'h80});
        t_write_ignored();
        for (int n = 0; n < 12; n++) begin
            for (int r = 0; r < K; r++) rv[r] = DW'($urandom);
            sort_and_check($sformatf("random%0d", n), rv);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule